// File: doc/BRIEF.md
# Time Synchronization Validity Supervisor

The supervisor keeps a seconds-of-day counter that advances on a one-second tick and judges every decoded frame from an external time reference against it. A frame decoder sits upstream. Once per frame it hands over the decoded time in seconds, a format-error flag and a leap-second announcement. A source-select input tells the supervisor whether frames arrive every second or once per minute.

A frame that is correctly formed and continues the running local time counts as a synchronization event. When frames stop or are rejected, the local counter runs free through a holdover window. If no frame is accepted for `HOLD_SEC` ticks, a time-error flag rises. If none is accepted within the validity reserve, an unsynchronized flag rises as well. While unsynchronized, the block takes its time from the next well-formed frame, whatever value that frame carries. A frame that lands one second away from local time is rejected as discontinuous, which is how an unannounced inserted second shows up. An announced leap second is applied to the local counter instead.

Top module: `tsync_supervisor`

## Requirements
- R1: While reset is asserted, and in the cycle after release, `local_time` is 0 and `status` is 4'b1100: unsynchronized (bit 3) and time-error (bit 2) are set, and accept strobe (bit 1) and leap pending (bit 0) are clear.
- R2: Each `sec_tick` pulse advances `local_time` by one on the next clock. The value DAY_SEC-1 wraps to 0.
- R3: With `src_dcf`=0 and bit 3 clear, a frame is accepted when `frame_fmt_err` is 0, the time is below DAY_SEC, and the time equals `local_time`. Acceptance clears bits 2 and 3 without changing `local_time`, and raises bit 1 for exactly one cycle.
- R4: With `src_dcf`=1, a frame is accepted only if, in addition, its time is a multiple of MIN_SEC (60).
- R5: Bit 2 sets on the tick that brings the number of ticks since the last accepted or reloaded frame to HOLD_SEC, and not earlier.
- R6: Bit 3 sets on the tick that brings that same count to `reserve_sec`. It stays set until a reload.
- R7: A frame that has a format error, is out of range or is discontinuous does not change `local_time`, does not restart the tick count and does not raise bit 1.
- R8: While bit 3 is set, the next well-formed frame loads its time into `local_time` on the next clock, clears bits 2 and 3, and raises bit 1.
- R9: An accepted frame with `frame_leap`=1 sets bit 0. While bit 0 is set, the tick at DAY_SEC-1 leaves `local_time` unchanged once and clears bit 0, so a following frame carrying DAY_SEC-1 is accepted.
- R10: A frame one second behind `local_time` (an inserted second without announcement) is rejected. Frames stay rejected until the reserve runs out and a reload aligns the local time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| sec_tick | input | 1 | One-cycle pulse per second |
| src_dcf | input | 1 | 0: one frame per second; 1: one frame per minute |
| frame_vld | input | 1 | Decoded frame strobe |
| frame_time | input | TIME_W | Decoded seconds of day |
| frame_fmt_err | input | 1 | Decoder found the frame malformed |
| frame_leap | input | 1 | Frame announces an inserted leap second |
| reserve_sec | input | RES_W | Validity reserve, in seconds (3600 at system reset) |
| local_time | output | TIME_W | Running seconds of day |
| status | output | 4 | {unsync, time_err, accept strobe, leap pending} |

## Verification
The bench builds the block with DAY_SEC=120 and HOLD_SEC=20, and drives a reserve of 50 seconds that it later raises to 100. These short windows put the day wrap, an announced leap at the end of the day, the holdover error, reserve expiry after an unannounced inserted second, and the reload within a few hundred ticks. The per-minute mode is then reached in the same run: an off-minute frame is rejected, and an on-minute frame recovers the error flag only because the raised reserve keeps the block from reaching the unsynchronized state.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  localparam int ST_W      = 4;
  localparam int ST_LEAP   = 0;
  localparam int ST_ACK    = 1;
  localparam int ST_TERR   = 2;
  localparam int ST_UNSYNC = 3;

  typedef enum logic [1:0] {
    FR_NONE   = 2'd0,
    FR_ACCEPT = 2'd1,
    FR_RELOAD = 2'd2
  } frame_act_e;
endpackage

// File: rtl/tsync_frame_check.sv
module tsync_frame_check
  import tsync_pkg::*;
#(
  parameter int DAY_SEC = 86400,
  parameter int MIN_SEC = 60,
  parameter int TIME_W  = $clog2(DAY_SEC)
) (
  input  logic              frame_vld_i,
  input  logic [TIME_W-1:0] frame_time_i,
  input  logic              fmt_err_i,
  input  logic              src_dcf_i,
  input  logic [TIME_W-1:0] local_time_i,
  input  logic              unsync_i,
  output frame_act_e        act_o
);
  localparam logic [TIME_W-1:0] LAST_C = TIME_W'(DAY_SEC - 1);
  localparam logic [TIME_W-1:0] MIN_C  = TIME_W'(MIN_SEC);

  logic in_range;
  logic on_minute;
  logic well_formed;

  always_comb begin
    in_range    = (frame_time_i <= LAST_C);
    on_minute   = ((frame_time_i % MIN_C) == '0);
    well_formed = !fmt_err_i && in_range && (!src_dcf_i || on_minute);
    act_o       = FR_NONE;
    if (frame_vld_i && well_formed) begin
      if (unsync_i)                          act_o = FR_RELOAD;
      else if (frame_time_i == local_time_i) act_o = FR_ACCEPT;
    end
  end
endmodule

// File: rtl/tsync_clock.sv
module tsync_clock #(
  parameter int DAY_SEC = 86400,
  parameter int TIME_W  = $clog2(DAY_SEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_time_i,
  input  logic              load_leap_i,
  input  logic              arm_leap_i,
  output logic [TIME_W-1:0] time_o,
  output logic              leap_o
);
  localparam logic [TIME_W-1:0] LAST_C = TIME_W'(DAY_SEC - 1);

  logic [TIME_W-1:0] time_q, time_d;
  logic              leap_q, leap_d;
  logic              at_last;
  logic              hold;

  always_comb begin
    at_last = (time_q == LAST_C);
    hold    = tick_i && leap_q && at_last;
    time_d  = time_q;
    leap_d  = leap_q;
    if (load_i) begin
      time_d = load_time_i;
      leap_d = load_leap_i;
    end else begin
      if (tick_i && !hold) time_d = at_last ? '0 : time_q + TIME_W'(1);
      if (arm_leap_i)      leap_d = 1'b1;
      else if (hold)       leap_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      leap_q <= 1'b0;
    end else begin
      time_q <= time_d;
      leap_q <= leap_d;
    end
  end

  assign time_o = time_q;
  assign leap_o = leap_q;

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && !leap_q && time_q == LAST_C) |=> (time_q == '0));
  // R7
  time_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(time_q));
  // R9
  leap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && !arm_leap_i && leap_q && time_q == LAST_C) |=> (time_q == LAST_C && !leap_q));
endmodule

// File: rtl/tsync_timers.sv
module tsync_timers #(
  parameter int HOLD_SEC = 600,
  parameter int RES_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [RES_W-1:0] reserve_i,
  output logic             err_o,
  output logic             unsync_o
);
  localparam int HOLD_W = $clog2(HOLD_SEC + 1);
  localparam int CNT_W  = ((RES_W > HOLD_W) ? RES_W : HOLD_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] HOLD_C  = CNT_W'(HOLD_SEC);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             err_q, err_d;
  logic             uns_q, uns_d;

  always_comb begin
    cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
    cnt_d   = cnt_q;
    err_d   = err_q;
    uns_d   = uns_q;
    if (clr_i) begin
      cnt_d = '0;
      err_d = 1'b0;
      uns_d = 1'b0;
    end else if (tick_i) begin
      cnt_d = cnt_inc;
      if (cnt_inc >= HOLD_C)              err_d = 1'b1;
      if (cnt_inc >= CNT_W'(reserve_i))   uns_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b1;
      uns_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
      uns_q <= uns_d;
    end
  end

  assign err_o    = err_q;
  assign unsync_o = uns_q;

  // R6
  unsync_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uns_q) |-> $past(tick_i));
  // R5
  err_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(tick_i));
  // R3
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!err_q && !uns_q && cnt_q == '0));
endmodule

// File: rtl/tsync_supervisor.sv
module tsync_supervisor
  import tsync_pkg::*;
#(
  parameter int DAY_SEC  = 86400,
  parameter int HOLD_SEC = 600,
  parameter int MIN_SEC  = 60,
  parameter int RES_W    = 16,
  localparam int TIME_W  = $clog2(DAY_SEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              src_dcf,
  input  logic              frame_vld,
  input  logic [TIME_W-1:0] frame_time,
  input  logic              frame_fmt_err,
  input  logic              frame_leap,
  input  logic [RES_W-1:0]  reserve_sec,
  output logic [TIME_W-1:0] local_time,
  output logic [ST_W-1:0]   status
);
  localparam logic [TIME_W-1:0] LAST_C = TIME_W'(DAY_SEC - 1);

  frame_act_e act;
  logic       load, accepted, arm_leap;
  logic       leap_pend, err_flag, uns_flag;
  logic       ack_q, ack_d;

  tsync_frame_check #(.DAY_SEC(DAY_SEC), .MIN_SEC(MIN_SEC), .TIME_W(TIME_W)) u_check (
    .frame_vld_i (frame_vld),
    .frame_time_i(frame_time),
    .fmt_err_i   (frame_fmt_err),
    .src_dcf_i   (src_dcf),
    .local_time_i(local_time),
    .unsync_i    (uns_flag),
    .act_o       (act)
  );

  always_comb begin
    load     = (act == FR_RELOAD);
    accepted = (act != FR_NONE);
    arm_leap = (act == FR_ACCEPT) && frame_leap;
    ack_d    = accepted;
  end

  tsync_clock #(.DAY_SEC(DAY_SEC), .TIME_W(TIME_W)) u_clock (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (sec_tick),
    .load_i     (load),
    .load_time_i(frame_time),
    .load_leap_i(frame_leap),
    .arm_leap_i (arm_leap),
    .time_o     (local_time),
    .leap_o     (leap_pend)
  );

  tsync_timers #(.HOLD_SEC(HOLD_SEC), .RES_W(RES_W)) u_timers (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (sec_tick),
    .clr_i    (accepted),
    .reserve_i(reserve_sec),
    .err_o    (err_flag),
    .unsync_o (uns_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  always_comb begin
    status            = '0;
    status[ST_LEAP]   = leap_pend;
    status[ST_ACK]    = ack_q;
    status[ST_TERR]   = err_flag;
    status[ST_UNSYNC] = uns_flag;
  end

  // R7
  bad_frame_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && frame_fmt_err) |=> !status[ST_ACK]);
  // R3
  ack_flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_ACK] |-> (!status[ST_TERR] && !status[ST_UNSYNC]));
  // R8
  reload_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && !frame_fmt_err && !src_dcf && status[ST_UNSYNC] && frame_time <= LAST_C)
      |=> (local_time == $past(frame_time)));
endmodule

// File: tb/tsync_supervisor_bench.sv
module tsync_supervisor_bench;
  localparam int DAY  = 120;
  localparam int HOLD = 20;
  localparam int TW   = $clog2(DAY);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0, dcf = 1'b0, fvld = 1'b0, ffmt = 1'b0, fleap = 1'b0;
  logic [TW-1:0] ftime = '0;
  logic [15:0]   res = 16'd50;
  logic [TW-1:0] ltime;
  logic [3:0]    st;

  always #10 clk = ~clk;

  tsync_supervisor #(.DAY_SEC(DAY), .HOLD_SEC(HOLD), .MIN_SEC(60), .RES_W(16)) u_tsync_supervisor (
    .clk(clk), .rst_n(rst_n), .sec_tick(tick), .src_dcf(dcf), .frame_vld(fvld),
    .frame_time(ftime), .frame_fmt_err(ffmt), .frame_leap(fleap), .reserve_sec(res),
    .local_time(ltime), .status(st)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int m_time, m_cnt, m_err, m_uns, m_leap, m_ack;

  // behavioural reference model
  always @(posedge clk) begin
    int ok, acc, rel, nt, nc, ne, nu, nl;
    if (!rst_n) begin
      m_time = 0; m_cnt = 0; m_err = 1; m_uns = 1; m_leap = 0; m_ack = 0;
    end else begin
      ok  = (!ffmt && (!dcf || (int'(ftime) % 60) == 0) && int'(ftime) < DAY) ? 1 : 0;
      acc = 0; rel = 0;
      if (fvld && ok != 0) begin
        if (m_uns != 0) rel = 1;
        else if (int'(ftime) == m_time) acc = 1;
      end
      nt = m_time; nl = m_leap; nc = m_cnt; ne = m_err; nu = m_uns;
      if (rel != 0) begin
        nt = int'(ftime); nl = fleap ? 1 : 0;
      end else begin
        if (tick && !(m_leap != 0 && m_time == DAY-1)) nt = (m_time + 1) % DAY;
        if (acc != 0 && fleap) nl = 1;
        else if (tick && m_leap != 0 && m_time == DAY-1) nl = 0;
      end
      if (acc != 0 || rel != 0) begin
        nc = 0; ne = 0; nu = 0;
      end else if (tick) begin
        nc = m_cnt + 1;
        if (nc >= HOLD) ne = 1;
        if (nc >= int'(res)) nu = 1;
      end
      m_time = nt; m_leap = nl; m_cnt = nc; m_err = ne; m_uns = nu;
      m_ack = (acc != 0 || rel != 0) ? 1 : 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 local_time vs model", int'(ltime), m_time);
      chk("R5 time-error vs model", int'(st[2]), m_err);
      chk("R6 unsync vs model", int'(st[3]), m_uns);
      chk("R3 accept strobe vs model", int'(st[1]), m_ack);
      chk("R9 leap pending vs model", int'(st[0]), m_leap);
    end
  end

  task automatic sec();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(int t, bit fe, bit lp);
    ftime = TW'(t); ffmt = fe; fleap = lp; fvld = 1'b1;
    @(negedge clk);
    fvld = 1'b0; ffmt = 1'b0; fleap = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int lt;
    repeat (3) @(negedge clk);
    chk("R1 reset local_time", int'(ltime), 0);
    chk("R1 reset status", int'(st), 12);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after release", int'(st), 12);

    frame(30, 1'b1, 1'b0);
    chk("R7 malformed frame no reload", int'(ltime), 0);
    chk("R7 still unsync", int'(st[3]), 1);
    frame(30, 1'b0, 1'b0);
    chk("R8 reload time", int'(ltime), 30);
    chk("R8 flags cleared", int'(st[3:2]), 0);

    lt = 30;
    for (int i = 0; i < 5; i++) begin
      sec(); lt = lt + 1; frame(lt, 1'b0, 1'b0);
    end
    chk("R3 tracking time", int'(ltime), 35);
    chk("R3 flags clear while tracking", int'(st[3:2]), 0);

    for (int i = 0; i < HOLD-1; i++) begin
      sec(); lt = lt + 1; frame(lt, 1'b1, 1'b0);
    end
    chk("R7 malformed frames keep time", int'(ltime), 54);
    chk("R5 no error before holdover", int'(st[2]), 0);
    sec(); lt = lt + 1;
    chk("R5 error at holdover", int'(st[2]), 1);
    chk("R6 no unsync yet", int'(st[3]), 0);
    frame(54, 1'b0, 1'b0);
    chk("R10 frame one behind rejected", int'(st[2]), 1);
    frame(55, 1'b0, 1'b0);
    chk("R3 continuous frame clears error", int'(st[2]), 0);
    chk("R3 no reload on accept", int'(ltime), 55);

    for (int k = 0; k < 49; k++) begin
      sec(); lt = (lt + 1) % DAY; frame(lt - 1, 1'b0, 1'b0);
    end
    chk("R10 lagging frames rejected", int'(st[2]), 1);
    chk("R6 unsync not before reserve", int'(st[3]), 0);
    sec(); lt = lt + 1;
    chk("R6 unsync at reserve", int'(st[3]), 1);
    chk("R2 free-running time", int'(ltime), 105);
    frame(104, 1'b0, 1'b0);
    chk("R10 reload realigns time", int'(ltime), 104);
    chk("R8 flags cleared on reload", int'(st[3:2]), 0);
    lt = 104;

    frame(104, 1'b0, 1'b1);
    chk("R9 leap armed", int'(st[0]), 1);
    for (int i = 0; i < 15; i++) begin
      sec(); lt = lt + 1; frame(lt, 1'b0, 1'b0);
    end
    chk("R2 end of day reached", int'(ltime), 119);
    sec();
    chk("R9 leap tick holds time", int'(ltime), 119);
    chk("R9 leap pending cleared", int'(st[0]), 0);
    frame(119, 1'b0, 1'b0);
    chk("R9 repeated second accepted", int'(st[2]), 0);
    sec();
    chk("R2 wrap to zero", int'(ltime), 0);

    dcf = 1'b1; res = 16'd100;
    sec();
    frame(1, 1'b0, 1'b0);
    for (int i = 0; i < 18; i++) sec();
    chk("R4 off-minute frame rejected", int'(st[2]), 1);
    chk("R2 time in minute mode", int'(ltime), 19);
    for (int i = 0; i < 41; i++) sec();
    frame(60, 1'b0, 1'b0);
    chk("R4 minute frame accepted", int'(st[2]), 0);
    chk("R4 time kept", int'(ltime), 60);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule